// File: doc/BRIEF.md
# Two-Model Probability Update Pipeline

This block produces the refreshed model weights of a two-model interacting multiple model tracker, once per measurement frame. Weights and likelihoods are unsigned Q1.15 numbers, so 1.0 is 32768. The block first forms each model's predicted weight from its held weights and a 2x2 switching matrix. It then scales each likelihood by that predicted weight and divides each of the two products by their sum.

The two likelihoods come in as a serial stream, one word per accepted `in_en`. The work runs through fixed-latency units:
- a pair of 5-cycle multipliers;
- a 7-cycle adder, with the products carried alongside it in matching registers;
- one 16-stage restoring divider shared by both models.

The two results leave on consecutive cycles. Two separate enables mark them: one feeds the downstream state-combination stage and one writes the internal loop store. The loop store supplies the held weights for the next frame. The first frame after reset uses the initial weights instead.

Top module: `imm_prob_update`

## Requirements
- R1: While reset is applied and after its release, `busy`, `out_comb_en`, `out_fifo_en` and `err_zero` are 0.
- R2: With predecessor weights p0 and p1, model j's predicted weight is floor((T[0][j]*p0 + T[1][j]*p1) / 32768). By default the diagonal entries of T are 32440 (0.99) and the off-diagonal entries are 328 (0.01).
- R3: With q_j = floor(L_j * pred_j / 32768) and a nonzero sum S = q0 + q1, the result for model j is floor(q_j * 32768 / S).
- R4: The model-0 result appears with `out_model`=0 exactly 28 cycles (5+7+16) after the clock edge that accepts the second likelihood. The model-1 result follows on the next cycle with `out_model`=1.
- R5: `out_comb_en` is high on exactly the two result cycles. `out_fifo_en` is high on those same cycles until both weights of the frame are stored, and it is low afterwards.
- R6: The first frame after reset uses predecessor weights 16384 and 16384. Every later frame uses the two results of the frame before it.
- R7: When S is 0, the block issues the predicted weights unchanged and sets `err_zero`. `err_zero` then stays high until reset.
- R8: `busy` rises on the edge that accepts the second likelihood and falls on the edge that issues the model-1 result. Any `in_en` seen while `busy` is high is ignored.
- R9: The first `in_en` accepted while idle carries the model-0 likelihood. The next accepted `in_en` carries the model-1 likelihood, and idle cycles may separate the two.
- R10: No issued result exceeds 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Input word strobe |
| in_data | input | 16 | Likelihood word, Q1.15 unsigned |
| busy | output | 1 | Frame in flight; input strobes ignored |
| out_comb_en | output | 1 | Result valid toward the state-combination stage |
| out_fifo_en | output | 1 | Result write strobe toward the loop store |
| out_model | output | 1 | Model index of the current result |
| out_data | output | 16 | Updated weight, Q1.15 unsigned |
| err_zero | output | 1 | Sticky flag: a frame had a zero normalising sum |

## Verification
Random likelihood pairs exercise rounding of the multiply, add and divide chain across many ratios. A run of chained frames shows whether the loop store carries weights from one frame into the next predictions.

Several directed cases each isolate one behaviour:
- Equal likelihoods on the first frame separate the initial-weight path from the loop path.
- One zero likelihood drives the results to the extremes 0 and 32768.
- Two zero likelihoods force the fallback path and the sticky flag.
- A gap between the two input words shows that the word order is tracked.
- A stray strobe during a frame shows that it is ignored.
- A mid-run reset shows that the initial weights come back.

// File: rtl/imm_prob_pkg.sv
package imm_prob_pkg;
   localparam int PROB_W = 16;
   localparam int PROB_F = PROB_W - 1;
   typedef logic [PROB_W-1:0] prob_t;
   localparam prob_t PROB_ONE  = prob_t'(1) << PROB_F;
   localparam prob_t PROB_HALF = PROB_ONE >> 1;
   typedef enum logic [1:0] {ST_IDLE, ST_HALF, ST_RUN} fsm_t;
endpackage

// File: rtl/imm_dly.sv
module imm_dly #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   initial begin
      assert (DEPTH >= 1) else $error("imm_dly: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/imm_div_pipe.sv
module imm_div_pipe
   import imm_prob_pkg::*;
#(
   parameter int W = PROB_W,
   parameter int F = PROB_F
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_v,
   input  logic         in_idx,
   input  logic [W-1:0] in_num,
   input  logic [W:0]   in_den,
   input  logic [W-1:0] in_alt,
   output logic         out_v,
   output logic         out_idx,
   output logic [W-1:0] out_res,
   output logic         out_zero,
   output logic         near_done
);
   localparam int L  = W;
   localparam int DW = W + F;

   initial begin
      assert (L >= 2) else $error("imm_div_pipe: need at least two stages");
   end

   logic [DW-1:0] dvd;
   assign dvd = {in_num, {F{1'b0}}};

   logic [W:0]   rem_q [L];
   logic [W:0]   den_q [L];
   logic [W-1:0] dlo_q [L];
   logic [W-1:0] quo_q [L];
   logic [W-1:0] alt_q [L];
   logic         v_q   [L];
   logic         idx_q [L];
   logic         zero_q[L];

   for (genvar s = 0; s < L; s++) begin : g_stage
      logic [W:0]   r_in, dv_in, rem_nx;
      logic [W-1:0] d_in, q_in, a_in;
      logic         z_in, vi, ii, take;
      logic [W+1:0] trial;
      if (s == 0) begin : g_head
         assign r_in  = (W+1)'(dvd >> W);
         assign d_in  = dvd[W-1:0];
         assign q_in  = '0;
         assign dv_in = in_den;
         assign a_in  = in_alt;
         assign z_in  = (in_den == '0);
         assign vi    = in_v;
         assign ii    = in_idx;
      end else begin : g_body
         assign r_in  = rem_q[s-1];
         assign d_in  = dlo_q[s-1];
         assign q_in  = quo_q[s-1];
         assign dv_in = den_q[s-1];
         assign a_in  = alt_q[s-1];
         assign z_in  = zero_q[s-1];
         assign vi    = v_q[s-1];
         assign ii    = idx_q[s-1];
      end
      assign trial  = {r_in, d_in[W-1]};
      assign take   = (trial >= {1'b0, dv_in});
      assign rem_nx = take ? (trial[W:0] - dv_in) : trial[W:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q[s] <= '0; den_q[s] <= '0; dlo_q[s] <= '0; quo_q[s] <= '0;
            alt_q[s] <= '0; v_q[s] <= 1'b0; idx_q[s] <= 1'b0; zero_q[s] <= 1'b0;
         end else begin
            rem_q[s]  <= rem_nx;
            den_q[s]  <= dv_in;
            dlo_q[s]  <= d_in << 1;
            quo_q[s]  <= q_in | ({{(W-1){1'b0}}, take} << (W-1-s));
            alt_q[s]  <= a_in;
            v_q[s]    <= vi;
            idx_q[s]  <= ii;
            zero_q[s] <= z_in;
         end
      end
   end

   logic div_unused;
   assign div_unused = ^{rem_q[L-1], den_q[L-1], dlo_q[L-1]};

   assign out_v     = v_q[L-1];
   assign out_idx   = idx_q[L-1];
   assign out_zero  = zero_q[L-1];
   assign out_res   = zero_q[L-1] ? alt_q[L-1] : quo_q[L-1];
   assign near_done = v_q[L-2] & idx_q[L-2];

   // R10
   quot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_v && !out_zero) |-> (quo_q[L-1] <= (W'(1) << F)));
endmodule

// File: rtl/imm_prob_update.sv
module imm_prob_update
   import imm_prob_pkg::*;
#(
   parameter int    MUL_LAT = 5,
   parameter int    ADD_LAT = 7,
   parameter prob_t TP00    = 16'd32440,
   parameter prob_t TP01    = 16'd328,
   parameter prob_t TP10    = 16'd328,
   parameter prob_t TP11    = 16'd32440,
   parameter prob_t INIT0   = PROB_HALF,
   parameter prob_t INIT1   = PROB_HALF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_en,
   input  logic [PROB_W-1:0] in_data,
   output logic              busy,
   output logic              out_comb_en,
   output logic              out_fifo_en,
   output logic              out_model,
   output logic [PROB_W-1:0] out_data,
   output logic              err_zero
);
   localparam int W   = PROB_W;
   localparam int F   = PROB_F;
   localparam int PW  = 2 * W;
   localparam int AW2 = 2 * W + 1;
   localparam int MW  = 1 + 4 * W;
   localparam int SW  = MW + W + 1;

   initial begin
      assert (MUL_LAT >= 1 && ADD_LAT >= 1) else $error("imm_prob_update: latencies must be positive");
      assert (32'(TP00) + 32'(TP01) == 32'(PROB_ONE)) else $error("imm_prob_update: row 0 must sum to one");
      assert (32'(TP10) + 32'(TP11) == 32'(PROB_ONE)) else $error("imm_prob_update: row 1 must sum to one");
      assert (32'(INIT0) + 32'(INIT1) <= 32'(PROB_ONE)) else $error("imm_prob_update: initial weights exceed one");
   end

   fsm_t  st_q;
   prob_t lik0_q, lik1_q, pred0_q, pred1_q, keep0_q, keep1_q;
   logic  launch_q, first_q, err_q;
   logic [1:0] stored_q;
   logic  busy_clr;

   // prediction from held or initial weights
   prob_t prev0, prev1, pred0_c, pred1_c;
   logic [AW2-1:0] acc0, acc1;
   assign prev0   = first_q ? INIT0 : keep0_q;
   assign prev1   = first_q ? INIT1 : keep1_q;
   assign acc0    = AW2'(TP00) * AW2'(prev0) + AW2'(TP10) * AW2'(prev1);
   assign acc1    = AW2'(TP01) * AW2'(prev0) + AW2'(TP11) * AW2'(prev1);
   assign pred0_c = prob_t'(acc0 >> F);
   assign pred1_c = prob_t'(acc1 >> F);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; launch_q <= 1'b0;
         lik0_q <= '0; lik1_q <= '0; pred0_q <= '0; pred1_q <= '0;
      end else begin
         launch_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (in_en) begin
               lik0_q <= in_data;
               st_q   <= ST_HALF;
            end
            ST_HALF: if (in_en) begin
               lik1_q   <= in_data;
               pred0_q  <= pred0_c;
               pred1_q  <= pred1_c;
               launch_q <= 1'b1;
               st_q     <= ST_RUN;
            end
            default: if (busy_clr) st_q <= ST_IDLE;
         endcase
      end
   end
   assign busy = (st_q == ST_RUN);

   // multiplier stage
   prob_t prod0_c, prod1_c;
   assign prod0_c = prob_t'((PW'(lik0_q) * PW'(pred0_q)) >> F);
   assign prod1_c = prob_t'((PW'(lik1_q) * PW'(pred1_q)) >> F);

   logic [MW-1:0] m_in, m_out;
   assign m_in = {launch_q, pred1_q, pred0_q, prod1_c, prod0_c};
   imm_dly #(.WIDTH(MW), .DEPTH(MUL_LAT)) u_mul (.clk(clk), .rst_n(rst_n), .din(m_in), .dout(m_out));

   logic  m_v;
   prob_t m_pred1, m_pred0, m_prod1, m_prod0;
   assign {m_v, m_pred1, m_pred0, m_prod1, m_prod0} = m_out;

   // adder stage, products and predictions delay-matched alongside
   logic [W:0] sum_c;
   assign sum_c = {1'b0, m_prod0} + {1'b0, m_prod1};

   logic [SW-1:0] s_in, s_out;
   assign s_in = {m_v, m_pred1, m_pred0, m_prod1, m_prod0, sum_c};
   imm_dly #(.WIDTH(SW), .DEPTH(ADD_LAT)) u_add (.clk(clk), .rst_n(rst_n), .din(s_in), .dout(s_out));

   logic       a_v;
   prob_t      a_pred1, a_pred0, a_prod1, a_prod0;
   logic [W:0] a_sum;
   assign {a_v, a_pred1, a_pred0, a_prod1, a_prod0, a_sum} = s_out;

   // second operand pair waits one cycle for the shared divider
   logic       h_v;
   prob_t      h_prod1, h_pred1;
   logic [W:0] h_sum;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_v <= 1'b0; h_prod1 <= '0; h_pred1 <= '0; h_sum <= '0;
      end else begin
         h_v <= a_v; h_prod1 <= a_prod1; h_pred1 <= a_pred1; h_sum <= a_sum;
      end
   end

   logic       d_v, d_idx, r_v, r_idx, r_zero;
   prob_t      d_num, d_alt, r_res;
   logic [W:0] d_den;
   assign d_v   = a_v | h_v;
   assign d_idx = ~a_v;
   assign d_num = a_v ? a_prod0 : h_prod1;
   assign d_den = a_v ? a_sum   : h_sum;
   assign d_alt = a_v ? a_pred0 : h_pred1;

   imm_div_pipe #(.W(W), .F(F)) u_div (
      .clk(clk), .rst_n(rst_n), .in_v(d_v), .in_idx(d_idx), .in_num(d_num),
      .in_den(d_den), .in_alt(d_alt), .out_v(r_v), .out_idx(r_idx),
      .out_res(r_res), .out_zero(r_zero), .near_done(busy_clr));

   assign out_comb_en = r_v;
   assign out_model   = r_idx;
   assign out_data    = r_res;
   assign out_fifo_en = r_v && (stored_q != 2'd2);
   assign err_zero    = err_q;

   // loop store and its write control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep0_q <= '0; keep1_q <= '0; first_q <= 1'b1; stored_q <= '0; err_q <= 1'b0;
      end else begin
         if (launch_q) stored_q <= '0;
         if (out_fifo_en) begin
            stored_q <= stored_q + 2'd1;
            if (r_idx) begin
               keep1_q <= r_res;
               first_q <= 1'b0;
            end else begin
               keep0_q <= r_res;
            end
         end
         if (r_v && r_zero) err_q <= 1'b1;
      end
   end

   // R8
   idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_en) |=> ($stable(lik0_q) && $stable(lik1_q)));
   // R4
   order_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_comb_en) |-> !out_model);
   // R4
   order_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_comb_en) |=> (out_comb_en && out_model));
   // R5
   fifo_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_comb_en) |-> (stored_q == 2'd2));
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_zero |=> err_zero);
   // R10
   prob_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_comb_en |-> (out_data <= PROB_ONE));
endmodule

// File: tb/imm_prob_update_tb_top.sv
module imm_prob_update_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_en = 1'b0;
   logic [15:0] in_data = '0;
   logic busy, out_comb_en, out_fifo_en, out_model, err_zero;
   logic [15:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   longint exp_p0 = 16384;
   longint exp_p1 = 16384;
   bit exp_err = 1'b0;

   always #10 clk = ~clk;

   imm_prob_update dut_i (
      .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_data(in_data), .busy(busy),
      .out_comb_en(out_comb_en), .out_fifo_en(out_fifo_en), .out_model(out_model),
      .out_data(out_data), .err_zero(err_zero));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint predict(input int j, input longint p0, input longint p1);
      longint t0, t1;
      t0 = (j == 0) ? 32440 : 328;
      t1 = (j == 0) ? 328 : 32440;
      return (t0 * p0 + t1 * p1) >> 15;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      in_en = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      chk(busy == 1'b0, "R1 busy in reset", busy, 0);
      chk(out_comb_en == 1'b0 && out_fifo_en == 1'b0, "R1 enables in reset", {out_comb_en, out_fifo_en}, 0);
      chk(err_zero == 1'b0, "R1 err in reset", err_zero, 0);
      rst_n = 1'b1;
      exp_p0 = 16384;
      exp_p1 = 16384;
      exp_err = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_frame(input longint l0, input longint l1, input int gap, input bit poke, input string tag);
      longint pr0, pr1, q0, q1, sm, e0, e1;
      int first_k;
      bit z;
      pr0 = predict(0, exp_p0, exp_p1);
      pr1 = predict(1, exp_p0, exp_p1);
      q0 = (l0 * pr0) >> 15;
      q1 = (l1 * pr1) >> 15;
      sm = q0 + q1;
      z = (sm == 0);
      if (z) begin
         e0 = pr0;
         e1 = pr1;
         exp_err = 1'b1;
      end else begin
         e0 = (q0 << 15) / sm;
         e1 = (q1 << 15) / sm;
      end
      // R9: model-0 word first, optional idle gap before the model-1 word
      @(negedge clk);
      in_en = 1'b1;
      in_data = 16'(l0);
      @(negedge clk);
      if (gap > 0) begin
         in_en = 1'b0;
         repeat (gap) @(negedge clk);
      end
      in_en = 1'b1;
      in_data = 16'(l1);
      @(posedge clk);
      @(negedge clk);
      in_en = 1'b0;
      // R8
      chk(busy == 1'b1, {"R8 busy after second word ", tag}, busy, 1);
      first_k = -1;
      for (int k = 0; k < 40; k++) begin
         if (k > 0) @(negedge clk);
         if (poke) begin
            in_en = (k == 3);
            in_data = 16'hFFFF;
         end
         if (k == 27) chk(busy == 1'b1, {"R8 busy held ", tag}, busy, 1);
         if (out_comb_en && first_k < 0) first_k = k;
         if (first_k >= 0 && k == first_k) begin
            // R4
            chk(first_k == 28, {"R4 latency ", tag}, first_k, 28);
            chk(out_model == 1'b0, {"R4 model0 order ", tag}, out_model, 0);
            // R3 R2 R6
            chk(longint'(out_data) == e0, {"R3 model0 value ", tag}, out_data, e0);
            // R5
            chk(out_fifo_en == 1'b1, {"R5 fifo enable word0 ", tag}, out_fifo_en, 1);
         end
         if (first_k >= 0 && k == first_k + 1) begin
            chk(out_comb_en == 1'b1 && out_model == 1'b1, {"R4 model1 next cycle ", tag}, {out_comb_en, out_model}, 3);
            chk(longint'(out_data) == e1, {"R3 model1 value ", tag}, out_data, e1);
            chk(out_fifo_en == 1'b1, {"R5 fifo enable word1 ", tag}, out_fifo_en, 1);
            // R7
            chk(err_zero == exp_err, {"R7 error flag ", tag}, err_zero, exp_err);
            // R8
            chk(busy == 1'b0, {"R8 busy falls with last result ", tag}, busy, 0);
         end
         if (first_k >= 0 && k == first_k + 2) begin
            chk(out_comb_en == 1'b0 && out_fifo_en == 1'b0, {"R5 enables closed ", tag}, {out_comb_en, out_fifo_en}, 0);
            break;
         end
      end
      if (first_k < 0) chk(1'b0, {"R4 no result ", tag}, -1, 28);
      exp_p0 = e0;
      exp_p1 = e1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R6 first frame uses initial weights
      run_frame(32768, 32768, 0, 1'b0, "equal first");
      run_frame(40000, 10000, 0, 1'b0, "chained");
      // R9 gap between words
      run_frame(12000, 30000, 3, 1'b0, "gap");
      // R8 stray strobe while busy
      run_frame(25000, 25000, 0, 1'b1, "poke");
      run_frame(30000, 5000, 0, 1'b0, "after poke");
      // R3 extremes
      run_frame(0, 20000, 0, 1'b0, "one zero");
      run_frame(65535, 65535, 0, 1'b0, "max");
      run_frame(65535, 1, 1, 1'b0, "skewed");
      for (int i = 0; i < 20; i++) begin
         run_frame(longint'($urandom_range(65535)), longint'($urandom_range(65535)),
                   int'($urandom_range(2)), 1'b0, "random");
      end
      // R7 zero sum, then stickiness
      run_frame(0, 0, 0, 1'b0, "zero sum");
      run_frame(20000, 20000, 0, 1'b0, "after zero");
      // R6 R1 reset restores the initial weights
      do_reset();
      run_frame(10000, 30000, 0, 1'b0, "after reset");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule